// File: doc/BRIEF.md
# Floating-Point Compare to Condition Field

This unit compares two double-precision IEEE-754 operands and turns the outcome into a 4-bit one-hot condition code. The code can mean less, greater, equal or unordered. On a clock edge where the strobe is high, the unit writes the code into two places. The first is the result-flag nibble of a 32-bit floating-point status word. The second is one 4-bit field of a 32-bit condition register, chosen by an index. Bits that are not written keep their incoming values.

Each operand is classified as a signalling NaN, a quiet NaN, a zero or an ordinary number (infinities count as ordinary numbers). Two compare flavours are supported: ordered and unordered. They differ in which invalid-operation sticky bits they raise when a NaN is involved. The unit also maintains the exception summary bit and the invalid summary bit. Arithmetic, rounding and trapping happen elsewhere.

The caller presents the operands, the compare flavour, the field index and the current status and condition words, then raises the strobe for one cycle. The updated words appear on the outputs after that edge and are held until the next strobe.

Top module: `fcmp_cond_unit`

## Requirements
- R1: The condition code is exactly one-hot: value 8 (bit 3) for less, 4 (bit 2) for greater, 2 (bit 1) for equal, 1 (bit 0) for unordered.
- R2: If either operand is a NaN (exponent all ones and a non-zero fraction), the code is unordered whatever the other operand is.
- R3: Non-NaN operands are ordered by signed value, infinities included, and positive and negative zero compare equal.
- R4: Status bits 15:12 are replaced by the code. Every status bit that no requirement names passes through unchanged.
- R5: Index k writes the code into condition-register bits 31-4k down to 28-4k. All other condition bits pass through unchanged.
- R6: In both flavours, a signalling-NaN operand (fraction MSB, bit 51, clear) sets status bit 24.
- R7: In the ordered flavour, a quiet-NaN operand (bit 51 set) with no signalling NaN present sets status bit 19. The unordered flavour never sets bit 19.
- R8: In the ordered flavour with a signalling-NaN operand, bit 19 is set only when the invalid-enable bit 7 of the incoming status is clear.
- R9: Status bit 31 becomes 1 when bit 24 or bit 19 changes from 0 to 1. Otherwise it keeps its incoming value.
- R10: Status bit 29 equals the OR of the updated bits 24:19 and 10:8.
- R11: Both output words reset to zero. They load only on a clock edge with the strobe high and otherwise hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Update strobe |
| ordered_i | input | 1 | 1 selects the ordered flavour, 0 the unordered flavour |
| field_i | input | 3 | Condition-register field index (0 is the top nibble) |
| op_a_i | input | 64 | First operand |
| op_b_i | input | 64 | Second operand |
| status_i | input | 32 | Current status word |
| cond_i | input | 32 | Current condition register |
| status_o | output | 32 | Updated status word |
| cond_o | output | 32 | Updated condition register |

## Verification
Directed pairs cover the following cases:
- ordinary less and greater pairs, which tell the magnitude path apart from the sign path;
- negative pairs, which catch a comparison that forgets to reverse when both signs are negative;
- positive and negative zero, which separates a bitwise equality test from a value equality test;
- infinity against finite values.

NaN cases cover both NaN kinds under both flavours, with the invalid-enable bit set and clear. Together these separate the bit-24 rule from the two bit-19 rules. Incoming status words with sticky bits already set show whether bit 31 reacts only to newly set bits.

Random operand pools then mix these classes with random patterns, random field indices and random status and condition words. Strobe-low cycles check that the outputs hold.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int CODE_W   = 4;
  localparam int CODE_LSB = 12;
  localparam int B_FX     = 31;
  localparam int B_VX     = 29;
  localparam int B_VXSNAN = 24;
  localparam int B_VXVC   = 19;
  localparam int B_VE     = 7;
  localparam logic [CODE_W-1:0] C_LT = 4'b1000;
  localparam logic [CODE_W-1:0] C_GT = 4'b0100;
  localparam logic [CODE_W-1:0] C_EQ = 4'b0010;
  localparam logic [CODE_W-1:0] C_UN = 4'b0001;

  typedef struct packed {
    logic nan;
    logic snan;
    logic qnan;
    logic zero;
    logic sign;
  } fp_class_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  localparam int FP_W = 1 + EXP_W + MAN_W
) (
  input  logic [FP_W-1:0] val,
  output fp_class_t       cls,
  output logic [FP_W-2:0] mag
);
  logic exp_ones, exp_zero, man_zero;
  assign exp_ones = &val[FP_W-2 -: EXP_W];
  assign exp_zero = ~|val[FP_W-2 -: EXP_W];
  assign man_zero = ~|val[MAN_W-1:0];
  assign mag      = val[FP_W-2:0];

  always_comb begin
    cls.sign = val[FP_W-1];
    cls.nan  = exp_ones & ~man_zero;
    cls.snan = cls.nan & ~val[MAN_W-1];
    cls.qnan = cls.nan & val[MAN_W-1];
    cls.zero = exp_zero & man_zero;
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  fp_class_t         cls_a,
  input  fp_class_t         cls_b,
  input  logic [MAG_W-1:0]  mag_a,
  input  logic [MAG_W-1:0]  mag_b,
  output logic [CODE_W-1:0] code
);
  function automatic logic [CODE_W-1:0] rank(
    input fp_class_t ca, input fp_class_t cb,
    input logic [MAG_W-1:0] ma, input logic [MAG_W-1:0] mb);
    logic [CODE_W-1:0] r;
    if (ca.nan || cb.nan)        r = C_UN;
    else if (ca.zero && cb.zero) r = C_EQ;
    else if (ca.sign != cb.sign) r = ca.sign ? C_LT : C_GT;
    else if (ma == mb)           r = C_EQ;
    else if ((ma < mb) ^ ca.sign) r = C_LT;
    else                         r = C_GT;
    return r;
  endfunction

  assign code = rank(cls_a, cls_b, mag_a, mag_b);
endmodule

// File: rtl/fcmp_flag_merge.sv
module fcmp_flag_merge
  import fcmp_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic [REG_W-1:0]  stat_in,
  input  logic [CODE_W-1:0] code,
  input  fp_class_t         cls_a,
  input  fp_class_t         cls_b,
  input  logic              ordered,
  output logic              snan_hit,
  output logic              vxvc_hit,
  output logic              new_sticky,
  output logic [REG_W-1:0]  stat_out
);
  logic any_q;
  logic [REG_W-1:0] s1;

  assign snan_hit = cls_a.snan | cls_b.snan;
  assign any_q    = cls_a.qnan | cls_b.qnan;
  assign vxvc_hit = ordered & (snan_hit ? ~stat_in[B_VE] : any_q);
  assign new_sticky = (snan_hit & ~stat_in[B_VXSNAN]) | (vxvc_hit & ~stat_in[B_VXVC]);

  always_comb begin
    s1 = stat_in;
    s1[CODE_LSB +: CODE_W] = code;
    if (snan_hit) s1[B_VXSNAN] = 1'b1;
    if (vxvc_hit) s1[B_VXVC]   = 1'b1;
    if (new_sticky) s1[B_FX]   = 1'b1;
    s1[B_VX] = (|s1[B_VXSNAN:B_VXVC]) | (|s1[10:8]);
    stat_out = s1;
  end
endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int MAN_W   = 52,
  parameter int NFIELD  = 8,
  localparam int FP_W   = 1 + EXP_W + MAN_W,
  localparam int REG_W  = NFIELD * CODE_W,
  localparam int IDX_W  = $clog2(NFIELD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             ordered_i,
  input  logic [IDX_W-1:0] field_i,
  input  logic [FP_W-1:0]  op_a_i,
  input  logic [FP_W-1:0]  op_b_i,
  input  logic [REG_W-1:0] status_i,
  input  logic [REG_W-1:0] cond_i,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] cond_o
);
  fp_class_t cls_a, cls_b;
  logic [FP_W-2:0] mag_a, mag_b;
  logic [CODE_W-1:0] code;
  logic snan_hit, vxvc_hit, new_sticky;
  logic [REG_W-1:0] status_nxt, cond_nxt;

  fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (.val(op_a_i), .cls(cls_a), .mag(mag_a));
  fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (.val(op_b_i), .cls(cls_b), .mag(mag_b));

  fcmp_order #(.MAG_W(FP_W-1)) u_order (
    .cls_a(cls_a), .cls_b(cls_b), .mag_a(mag_a), .mag_b(mag_b), .code(code));

  fcmp_flag_merge #(.REG_W(REG_W)) u_flags (
    .stat_in(status_i), .code(code), .cls_a(cls_a), .cls_b(cls_b),
    .ordered(ordered_i), .snan_hit(snan_hit), .vxvc_hit(vxvc_hit),
    .new_sticky(new_sticky), .stat_out(status_nxt));

  for (genvar k = 0; k < NFIELD; k++) begin : g_field
    assign cond_nxt[REG_W-1-CODE_W*k -: CODE_W] =
      (field_i == IDX_W'(k)) ? code : cond_i[REG_W-1-CODE_W*k -: CODE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o <= '0;
      cond_o   <= '0;
    end else if (valid_i) begin
      status_o <= status_nxt;
      cond_o   <= cond_nxt;
    end
  end
endmodule

// File: rtl/fcmp_cond_chk.sv
module fcmp_cond_chk
  import fcmp_pkg::*;
#(
  parameter int NFIELD = 8,
  parameter int FP_W   = 64,
  localparam int REG_W = NFIELD * CODE_W,
  localparam int IDX_W = $clog2(NFIELD)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid_i,
  input logic             ordered_i,
  input logic [IDX_W-1:0] field_i,
  input logic [FP_W-1:0]  op_a_i,
  input logic [FP_W-1:0]  op_b_i,
  input logic [REG_W-1:0] status_i,
  input logic [REG_W-1:0] status_o,
  input logic [REG_W-1:0] cond_o,
  input logic             snan_hit,
  input logic             vxvc_hit
);
  logic [IDX_W-1:0] field_d;
  logic [CODE_W-1:0] picked;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) field_d <= '0;
    else if (valid_i) field_d <= field_i;
  assign picked = CODE_W'(cond_o >> (REG_W - CODE_W - CODE_W * int'(field_d)));

  // R1
  code_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> $countones(status_o[CODE_LSB +: CODE_W]) == 1);
  // R5
  field_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> picked == status_o[CODE_LSB +: CODE_W]);
  // R2
  nan_unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ((&op_a_i[62:52] && |op_a_i[51:0]) || (&op_b_i[62:52] && |op_b_i[51:0])))
    |=> status_o[CODE_LSB]);
  // R6
  snan_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && snan_hit) |=> status_o[B_VXSNAN]);
  // R7
  unordered_no_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !ordered_i) |-> !vxvc_hit);
  // R9
  summary_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && status_i[B_FX]) |=> status_o[B_FX]);
  // R10
  invalid_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> status_o[B_VX] == ((|status_o[24:19]) | (|status_o[10:8])));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(status_o) && $stable(cond_o));
endmodule

bind fcmp_cond_unit fcmp_cond_chk #(.NFIELD(NFIELD), .FP_W(FP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .ordered_i(ordered_i),
  .field_i(field_i), .op_a_i(op_a_i), .op_b_i(op_b_i), .status_i(status_i),
  .status_o(status_o), .cond_o(cond_o), .snan_hit(snan_hit), .vxvc_hit(vxvc_hit));

// File: tb/tb_fcmp_cond_unit.sv
`timescale 1ns/1ps
module tb_fcmp_cond_unit;
  logic clk = 0, rst_n = 0, valid_i = 0, ordered_i = 0;
  logic [2:0] field_i = 0;
  logic [63:0] op_a_i = 0, op_b_i = 0;
  logic [31:0] status_i = 0, cond_i = 0, status_o, cond_o;
  logic [31:0] exp_s = 0, exp_c = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fcmp_cond_unit dut (.clk(clk), .rst_n(rst_n), .valid_i(valid_i), .ordered_i(ordered_i),
    .field_i(field_i), .op_a_i(op_a_i), .op_b_i(op_b_i), .status_i(status_i),
    .cond_i(cond_i), .status_o(status_o), .cond_o(cond_o));

  localparam logic [63:0] P0 = 64'h0, N0 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] P1 = 64'h3FF0_0000_0000_0000, N1 = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] P2 = 64'h4000_0000_0000_0000, N2 = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000, NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QN = 64'h7FF8_0000_0000_0001, SN = 64'h7FF0_0000_0000_0005;
  localparam logic [63:0] NSN = 64'hFFF4_0000_0000_0000, DEN = 64'h0000_0000_0000_0003;

  function automatic bit is_nan(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction

  task automatic model(input logic [63:0] a, b, input bit ord, input int f,
                       input logic [31:0] st, cd, output logic [31:0] so, co);
    logic [3:0] code;
    bit sn, qn, vc;
    sn = (is_nan(a) && !a[51]) || (is_nan(b) && !b[51]);
    qn = (is_nan(a) && a[51]) || (is_nan(b) && b[51]);
    if (is_nan(a) || is_nan(b)) code = 1;
    else if ($bitstoreal(a) < $bitstoreal(b)) code = 8;
    else if ($bitstoreal(a) > $bitstoreal(b)) code = 4;
    else code = 2;
    so = st;
    so[15:12] = code;
    vc = ord && (sn ? !st[7] : qn);
    if (sn) so[24] = 1;
    if (vc) so[19] = 1;
    if ((sn && !st[24]) || (vc && !st[19])) so[31] = 1;
    so[29] = (so[24:19] != 0) || (so[10:8] != 0);
    co = cd;
    co[31 - 4*f -: 4] = code;
  endtask

  task automatic compare(input string req);
    string tag;
    checks++;
    if (status_o !== exp_s || cond_o !== exp_c) begin
      errors++;
      tag = req;
      if (req == "") begin
        if (status_o[15:12] !== exp_s[15:12]) tag = "R1/R2/R3";
        else if (cond_o !== exp_c) tag = "R5";
        else if (status_o[24] !== exp_s[24]) tag = "R6";
        else if (status_o[19] !== exp_s[19]) tag = "R7/R8";
        else if (status_o[31] !== exp_s[31]) tag = "R9";
        else if (status_o[29] !== exp_s[29]) tag = "R10";
        else tag = "R4";
      end
      $display("FAIL %s: status=%h cond=%h expected status=%h cond=%h",
               tag, status_o, cond_o, exp_s, exp_c);
    end
  endtask

  task automatic step(input bit v, input bit ord, input int f, input logic [63:0] a, b,
                      input logic [31:0] st, cd, input string req);
    logic [31:0] s2, c2;
    valid_i = v; ordered_i = ord; field_i = 3'(f); op_a_i = a; op_b_i = b;
    status_i = st; cond_i = cd;
    if (v) begin
      model(a, b, ord, f, st, cd, s2, c2);
      exp_s = s2; exp_c = c2;
    end
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  function automatic logic [63:0] pick(input int unsigned r);
    case (r % 12)
      0: return P0;   1: return N0;   2: return P1;  3: return N1;
      4: return P2;   5: return N2;   6: return PINF; 7: return NINF;
      8: return QN;   9: return SN;  10: return NSN;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    compare("R11 reset");
    rst_n = 1;
    @(negedge clk);
    // R1 R3 ordinary ordering
    step(1, 1, 0, P1, P2, 32'h0, 32'h0, "R1 less");
    step(1, 1, 1, P2, P1, 32'h0, 32'hFFFF_FFFF, "R1 greater");
    step(1, 0, 2, N2, N1, 32'h0, 32'h0, "R3 negative less");
    step(1, 0, 3, N0, P0, 32'h0, 32'h0, "R3 signed zero equal");
    step(1, 0, 4, NINF, N2, 32'h0, 32'h0, "R3 -inf less");
    step(1, 0, 5, PINF, DEN, 32'h0, 32'h0, "R3 +inf greater");
    // R2 R7 quiet NaN in both flavours
    step(1, 1, 6, QN, P1, 32'h0, 32'h0, "R7 ordered qnan");
    step(1, 0, 7, P1, QN, 32'h0, 32'h0, "R7 unordered qnan");
    step(1, 0, 0, PINF, QN, 32'h0, 32'h0, "R2 nan vs inf");
    // R6 R8 signalling NaN
    step(1, 1, 1, SN, P1, 32'h0, 32'h0, "R8 snan ve clear");
    step(1, 1, 1, SN, QN, 32'h0000_0080, 32'h0, "R8 snan ve set");
    step(1, 0, 2, P0, NSN, 32'h0, 32'h0, "R6 unordered snan");
    // R9 bit already set: summary not forced
    step(1, 0, 3, SN, P1, 32'h0100_0000, 32'h0, "R9 no new sticky");
    // R10 from pre-existing bit 9
    step(1, 0, 4, P1, P1, 32'h0000_0200, 32'h0, "R10 existing invalid");
    // R4 passthrough of other bits
    step(1, 0, 5, P1, N1, 32'h5A5A_0F0F & ~32'h2000_0000, 32'h1234_5678, "R4 passthrough");
    // R5 every field index
    for (int k = 0; k < 8; k++)
      step(1, 0, k, N1, P1, 32'h0, 32'hA5C3_96E1, "R5 field index");
    // R11 hold while strobe low
    step(0, 1, 7, SN, QN, 32'hFFFF_FFFF, 32'h0, "R11 hold");
    step(0, 0, 0, P0, P1, 32'h0, 32'hFFFF_FFFF, "R11 hold");
    // random mix
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, $urandom % 2, $urandom % 8, pick($urandom), pick($urandom),
           $urandom, $urandom, "");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule